// File: doc/BRIEF.md
# Paged Wiper Register Bank Controller

This block is the register side of a quad digital potentiometer. It keeps one volatile wiper register per channel, a four-by-four bank of data registers (four rows, one entry per channel in each row), and a small volatile status register. The status register chooses whether data bytes address the wipers or the data registers, and which row of the bank is active. The data registers stand in for nonvolatile storage and are modelled as plain registers.

A serial bus slave, outside this block, turns bus activity into single-cycle events: an address byte received, a data byte received, a request to advance past a byte that was read, STOP, and abort. The block decodes the address byte into a channel pointer or a status-register target. It applies each data byte as a status write, a wiper write, or a data-register write, and serves read data. Every data-register access also moves the active row into the wipers.

Data-register bytes are held in a pending buffer. At STOP they are written into the bank only when the write-allow input is high. A one-cycle commit pulse then starts the external write cycle.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: After reset the status register is 0x00, the address mode is channel with the pointer at channel 0, and commit_o is low. Data register (row r, channel c) holds (0x11*(4r+c+1)) mod 256, and each wiper holds its row-0 value: 0x11, 0x22, 0x33, 0x44.
- R2: The address byte 0..3 selects that channel and sets the pointer, and 7 selects the status register. Every other value is unused: data bytes are then ignored, rd_data_o reads 0x00, and nothing is pended.
- R3: A data byte aimed at the status register stores its bits 2:0 (bit 0 = data-register select, bits 2:1 = row) and drops the rest. Reading the status register returns those three bits zero-extended.
- R4: A status write with bit 0 = 1 loads all four wipers from the chosen row by the next clock edge. With bit 0 = 0 the wipers are unchanged.
- R5: With status bit 0 = 0, a channel data byte writes only the wiper at the pointer.
- R6: With status bit 0 = 1, a channel data byte sets the wiper at the pointer to that byte. Every other wiper takes the byte already pending for it in this row, or else that row's stored data register.
- R7: The pointer advances after each channel data byte and after each read advance, wrapping from 3 to 0, so a fifth byte in one transfer overwrites the first channel's byte.
- R8: Data-register bytes are held pending until STOP. At STOP with nv_allow_i high they are written into the active row, and commit_o is high for exactly the one cycle after the STOP edge.
- R9: At STOP with nv_allow_i low the pending bytes are discarded, commit_o stays low, and the stored data registers keep their values.
- R10: abort_i discards all pending bytes. A later STOP then commits nothing and raises no pulse.
- R11: In channel mode rd_data_o shows the wiper at the pointer (status bit 0 = 0) or the pointer's data register in the active row (bit 0 = 1). A read advance with bit 0 = 1 also loads the whole row into the wipers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nv_allow_i | input | 1 | High allows pending data-register bytes to be written at STOP |
| addr_vld_i | input | 1 | Address byte received this cycle |
| addr_i | input | 8 | Address byte value |
| wr_vld_i | input | 1 | Data byte received this cycle |
| wr_data_i | input | 8 | Data byte value |
| rd_adv_i | input | 1 | The byte on rd_data_o was sent; advance |
| stop_i | input | 1 | STOP seen on the bus |
| abort_i | input | 1 | Transfer abandoned without STOP |
| rd_data_o | output | 8 | Byte to send for a read |
| wiper_o | output | 32 | Four wiper values, channel c at bits 8c+7:8c |
| commit_o | output | 1 | One-cycle pulse starting the nonvolatile write |

## Verification
The hardest state to reach is a row whose wipers differ both from the stored row and from one another in the middle of a page write. That state is what shows whether each wiper reload takes the pending byte or the stored value. The bench enters the data-register row through a status write, then sends five bytes starting at channel 1. It checks the wipers after the wrap to channel 0 and after the overwrite of channel 1. Only then does it close with STOP and read the row back across the wrap.

// File: rtl/wb_pkg.sv
package wb_pkg;

    localparam int WB_NCH     = 4;
    localparam int WB_NROW    = 4;
    localparam int WB_DW      = 8;
    localparam int WB_SR_CODE = 7;

    typedef enum logic [1:0] {
        AM_CHAN = 2'd0,
        AM_STAT = 2'd1,
        AM_NONE = 2'd2
    } amode_e;

    // Contents the data-register bank wakes up with.
    function automatic int wb_seed(input int r, input int c, input int nch);
        return (17 * (r * nch + c + 1)) % 256;
    endfunction

endpackage

// File: rtl/wb_addr_dec.sv
module wb_addr_dec
    import wb_pkg::*;
#(
    parameter int NCH     = WB_NCH,
    parameter int DW      = WB_DW,
    parameter int SR_CODE = WB_SR_CODE,
    localparam int CW     = $clog2(NCH)
) (
    input  logic [DW-1:0] code_i,
    output amode_e        mode_o,
    output logic [CW-1:0] chan_o
);

    always_comb begin
        chan_o = code_i[CW-1:0];
        if (int'(code_i) < NCH)
            mode_o = AM_CHAN;
        else if (int'(code_i) == SR_CODE)
            mode_o = AM_STAT;
        else
            mode_o = AM_NONE;
    end

endmodule

// File: rtl/wb_pend_buf.sv
module wb_pend_buf #(
    parameter int NCH  = 4,
    parameter int NROW = 4,
    parameter int DW   = 8,
    localparam int CW  = $clog2(NCH),
    localparam int RW  = $clog2(NROW)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [CW-1:0]           chan_i,
    input  logic [RW-1:0]           row_i,
    input  logic [DW-1:0]           data_i,
    input  logic                    clear_i,
    output logic [NCH-1:0]          valid_o,
    output logic [NCH-1:0][DW-1:0]  data_o,
    output logic [RW-1:0]           row_o
);

    typedef struct packed {
        logic [NCH-1:0]         valid;
        logic [NCH-1:0][DW-1:0] data;
        logic [RW-1:0]          row;
    } pb_t;

    pb_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clear_i) begin
            pb_d.valid = '0;
        end else if (load_i) begin
            // a byte for another row invalidates what was held
            if (pb_q.row != row_i)
                pb_d.valid = '0;
            pb_d.valid[chan_i] = 1'b1;
            pb_d.data[chan_i]  = data_i;
            pb_d.row           = row_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pb_q <= '0;
        else
            pb_q <= pb_d;
    end

    assign valid_o = pb_q.valid;
    assign data_o  = pb_q.data;
    assign row_o   = pb_q.row;

    // R10: a clear leaves nothing pending
    p_pend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (valid_o == '0));

endmodule

// File: rtl/wb_regfile.sv
module wb_regfile
    import wb_pkg::*;
#(
    parameter int NCH  = WB_NCH,
    parameter int NROW = WB_NROW,
    parameter int DW   = WB_DW,
    localparam int CW  = $clog2(NCH),
    localparam int RW  = $clog2(NROW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 allow_i,
    input  logic                 row_load_i,
    input  logic [RW-1:0]        load_row_i,
    input  logic                 wcr_wr_i,
    input  logic                 dr_wr_i,
    input  logic [CW-1:0]        chan_i,
    input  logic [RW-1:0]        row_i,
    input  logic [DW-1:0]        data_i,
    input  logic                 commit_i,
    input  logic                 abort_i,
    output logic [NCH*DW-1:0]    wiper_o,
    output logic [DW-1:0]        rd_wcr_o,
    output logic [DW-1:0]        rd_dr_o,
    output logic                 commit_o
);

    typedef struct packed {
        logic [NROW-1:0][NCH-1:0][DW-1:0] dr;
        logic [NCH-1:0][DW-1:0]           wcr;
        logic                             fire;
    } rf_t;

    rf_t rf_d, rf_q;

    logic [NCH-1:0]         pv;
    logic [NCH-1:0][DW-1:0] pdata;
    logic [RW-1:0]          prow;

    wb_pend_buf #(.NCH(NCH), .NROW(NROW), .DW(DW)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (dr_wr_i),
        .chan_i  (chan_i),
        .row_i   (row_i),
        .data_i  (data_i),
        .clear_i (commit_i | abort_i),
        .valid_o (pv),
        .data_o  (pdata),
        .row_o   (prow)
    );

    always_comb begin
        rf_d      = rf_q;
        rf_d.fire = 1'b0;
        if (row_load_i) begin
            for (int c = 0; c < NCH; c++)
                rf_d.wcr[c] = rf_q.dr[load_row_i][c];
        end
        if (wcr_wr_i)
            rf_d.wcr[chan_i] = data_i;
        if (dr_wr_i) begin
            for (int c = 0; c < NCH; c++) begin
                if (c == int'(chan_i))
                    rf_d.wcr[c] = data_i;
                else if (pv[c] && prow == row_i)
                    rf_d.wcr[c] = pdata[c];
                else
                    rf_d.wcr[c] = rf_q.dr[row_i][c];
            end
        end
        if (commit_i && (|pv) && allow_i) begin
            for (int c = 0; c < NCH; c++)
                if (pv[c])
                    rf_d.dr[prow][c] = pdata[c];
            rf_d.fire = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NROW; r++)
                for (int c = 0; c < NCH; c++)
                    rf_q.dr[r][c] <= DW'(wb_seed(r, c, NCH));
            for (int c = 0; c < NCH; c++)
                rf_q.wcr[c] <= DW'(wb_seed(0, c, NCH));
            rf_q.fire <= 1'b0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign wiper_o  = rf_q.wcr;
    assign rd_wcr_o = rf_q.wcr[chan_i];
    assign rd_dr_o  = rf_q.dr[row_i][chan_i];
    assign commit_o = rf_q.fire;

    // R9: stored rows change only through an allowed commit
    p_dr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_i && allow_i) |=> $stable(rf_q.dr));

    for (genvar g = 0; g < NCH; g++) begin : g_keep
        // R5: a single wiper write leaves the other wipers alone
        p_wcr_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wcr_wr_i && !row_load_i && !dr_wr_i && int'(chan_i) != g)
            |=> $stable(rf_q.wcr[g]));
    end

endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
    import wb_pkg::*;
#(
    parameter int NCH     = WB_NCH,
    parameter int NROW    = WB_NROW,
    parameter int DW      = WB_DW,
    parameter int SR_CODE = WB_SR_CODE,
    localparam int CW     = $clog2(NCH),
    localparam int RW     = $clog2(NROW),
    localparam int SRW    = RW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_allow_i,
    input  logic              addr_vld_i,
    input  logic [DW-1:0]     addr_i,
    input  logic              wr_vld_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic              rd_adv_i,
    input  logic              stop_i,
    input  logic              abort_i,
    output logic [DW-1:0]     rd_data_o,
    output logic [NCH*DW-1:0] wiper_o,
    output logic              commit_o
);

    typedef struct packed {
        logic [SRW-1:0] sr;
        amode_e         mode;
        logic [CW-1:0]  chan;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    amode_e        dec_mode;
    logic [CW-1:0] dec_chan;
    logic          wcr_wr, dr_wr, row_load, commit_req, pend_clear;
    logic [RW-1:0] load_row;
    logic [DW-1:0] rd_wcr, rd_dr;
    logic [CW-1:0] chan_nx;

    wb_addr_dec #(.NCH(NCH), .DW(DW), .SR_CODE(SR_CODE)) u_dec (
        .code_i (addr_i),
        .mode_o (dec_mode),
        .chan_o (dec_chan)
    );

    assign chan_nx = (int'(ctl_q.chan) == NCH - 1) ? '0 : ctl_q.chan + 1'b1;

    always_comb begin
        ctl_d      = ctl_q;
        wcr_wr     = 1'b0;
        dr_wr      = 1'b0;
        row_load   = 1'b0;
        load_row   = '0;
        commit_req = 1'b0;
        pend_clear = 1'b0;
        if (abort_i) begin
            pend_clear = 1'b1;
        end else if (stop_i) begin
            commit_req = 1'b1;
        end else if (addr_vld_i) begin
            ctl_d.mode = dec_mode;
            ctl_d.chan = dec_chan;
        end else if (wr_vld_i) begin
            case (ctl_q.mode)
                AM_STAT: begin
                    ctl_d.sr = wr_data_i[SRW-1:0];
                    if (wr_data_i[0]) begin
                        row_load = 1'b1;
                        load_row = wr_data_i[SRW-1:1];
                    end
                end
                AM_CHAN: begin
                    if (ctl_q.sr[0])
                        dr_wr = 1'b1;
                    else
                        wcr_wr = 1'b1;
                    ctl_d.chan = chan_nx;
                end
                default: ;
            endcase
        end else if (rd_adv_i && ctl_q.mode == AM_CHAN) begin
            ctl_d.chan = chan_nx;
            if (ctl_q.sr[0]) begin
                row_load = 1'b1;
                load_row = ctl_q.sr[SRW-1:1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.sr   <= '0;
            ctl_q.mode <= AM_CHAN;
            ctl_q.chan <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    wb_regfile #(.NCH(NCH), .NROW(NROW), .DW(DW)) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .allow_i    (nv_allow_i),
        .row_load_i (row_load),
        .load_row_i (load_row),
        .wcr_wr_i   (wcr_wr),
        .dr_wr_i    (dr_wr),
        .chan_i     (ctl_q.chan),
        .row_i      (ctl_q.sr[SRW-1:1]),
        .data_i     (wr_data_i),
        .commit_i   (commit_req),
        .abort_i    (pend_clear),
        .wiper_o    (wiper_o),
        .rd_wcr_o   (rd_wcr),
        .rd_dr_o    (rd_dr),
        .commit_o   (commit_o)
    );

    always_comb begin
        case (ctl_q.mode)
            AM_STAT: rd_data_o = DW'(ctl_q.sr);
            AM_CHAN: rd_data_o = ctl_q.sr[0] ? rd_dr : rd_wcr;
            default: rd_data_o = '0;
        endcase
    end

    // R9: a commit pulse follows only an allowed STOP
    p_commit_allowed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(stop_i) && $past(nv_allow_i) && !$past(abort_i)));

    // R7: the pointer wraps from the last channel to channel 0
    p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!abort_i && !stop_i && !addr_vld_i && wr_vld_i &&
         ctl_q.mode == AM_CHAN && int'(ctl_q.chan) == NCH - 1)
        |=> (ctl_q.chan == '0));

endmodule

// File: tb/sim_wiper_bank_ctrl.sv
module sim_wiper_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_allow = 1'b1;
    logic        addr_vld = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_vld = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_adv = 1'b0;
    logic        stop = 1'b0;
    logic        abort = 1'b0;
    logic [7:0]  rd_data;
    logic [31:0] wiper;
    logic        commit;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wiper_bank_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .nv_allow_i (nv_allow),
        .addr_vld_i (addr_vld),
        .addr_i     (addr),
        .wr_vld_i   (wr_vld),
        .wr_data_i  (wr_data),
        .rd_adv_i   (rd_adv),
        .stop_i     (stop),
        .abort_i    (abort),
        .rd_data_o  (rd_data),
        .wiper_o    (wiper),
        .commit_o   (commit)
    );

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic chk_wipers(input string tag, input logic [7:0] e0, input logic [7:0] e1,
                              input logic [7:0] e2, input logic [7:0] e3);
        chk8({tag, " w0"}, wiper[7:0],   e0);
        chk8({tag, " w1"}, wiper[15:8],  e1);
        chk8({tag, " w2"}, wiper[23:16], e2);
        chk8({tag, " w3"}, wiper[31:24], e3);
    endtask

    task automatic ev_addr(input logic [7:0] a);
        @(negedge clk); addr_vld = 1'b1; addr = a;
        @(negedge clk); addr_vld = 1'b0;
    endtask

    task automatic ev_wr(input logic [7:0] d);
        @(negedge clk); wr_vld = 1'b1; wr_data = d;
        @(negedge clk); wr_vld = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic ev_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    task automatic ev_rd(output logic [7:0] v);
        @(negedge clk); v = rd_data; rd_adv = 1'b1;
        @(negedge clk); rd_adv = 1'b0;
    endtask

    task automatic t_reset();
        chk_wipers("R1 reset wipers", 8'h11, 8'h22, 8'h33, 8'h44);
        chk8("R1 reset read ch0 (R11)", rd_data, 8'h11);
        chk8("R1 reset commit", {7'd0, commit}, 8'h00);
    endtask

    task automatic t_status_read();
        logic [7:0] v;
        ev_addr(8'h07);
        ev_rd(v);
        chk8("R3 status after reset", v, 8'h00);
        ev_stop();
        chk8("R3 stop with nothing pending", {7'd0, commit}, 8'h00);
    endtask

    task automatic t_wiper_write();
        ev_addr(8'h02);
        ev_wr(8'hA5);
        chk_wipers("R5 single wiper write", 8'h11, 8'h22, 8'hA5, 8'h44);
        ev_wr(8'h5A);
        chk_wipers("R7 pointer advanced to ch3", 8'h11, 8'h22, 8'hA5, 8'h5A);
        ev_stop();
    endtask

    task automatic t_status_load();
        logic [7:0] v;
        ev_addr(8'h07);
        ev_wr(8'h03);
        chk_wipers("R4 row1 load", 8'h55, 8'h66, 8'h77, 8'h88);
        ev_rd(v);
        chk8("R3 status readback", v, 8'h03);
        ev_wr(8'hFC);
        chk_wipers("R4 bit0=0 no load", 8'h55, 8'h66, 8'h77, 8'h88);
        ev_rd(v);
        chk8("R3 upper bits dropped", v, 8'h04);
        ev_wr(8'h03);
        ev_stop();
    endtask

    task automatic t_abort();
        logic [7:0] v;
        ev_addr(8'h02);
        ev_wr(8'h3A);
        chk_wipers("R6 dr write reload", 8'h55, 8'h66, 8'h3A, 8'h88);
        ev_abort();
        ev_stop();
        chk8("R10 no commit after abort", {7'd0, commit}, 8'h00);
        ev_addr(8'h02);
        ev_rd(v);
        chk8("R10 dr unchanged", v, 8'h77);
        chk_wipers("R11 read moves row", 8'h55, 8'h66, 8'h77, 8'h88);
        ev_rd(v);
        chk8("R11 read next ch3", v, 8'h88);
        ev_stop();
    endtask

    task automatic t_page();
        logic [7:0] v;
        ev_addr(8'h01);
        ev_wr(8'h01);
        ev_wr(8'h02);
        ev_wr(8'h03);
        ev_wr(8'h04);
        chk_wipers("R6 pending-aware reload", 8'h04, 8'h01, 8'h02, 8'h03);
        ev_wr(8'h05);
        chk_wipers("R7 fifth byte overwrites", 8'h04, 8'h05, 8'h02, 8'h03);
        ev_stop();
        chk8("R8 commit pulse", {7'd0, commit}, 8'h01);
        @(negedge clk);
        chk8("R8 pulse one cycle", {7'd0, commit}, 8'h00);
        ev_addr(8'h00);
        ev_rd(v); chk8("R8 committed ch0", v, 8'h04);
        ev_rd(v); chk8("R8 committed ch1", v, 8'h05);
        ev_rd(v); chk8("R8 committed ch2", v, 8'h02);
        ev_rd(v); chk8("R8 committed ch3", v, 8'h03);
        ev_rd(v); chk8("R7 read wrap to ch0", v, 8'h04);
        ev_stop();
    endtask

    task automatic t_protect();
        logic [7:0] v;
        nv_allow = 1'b0;
        ev_addr(8'h00);
        ev_wr(8'h99);
        chk_wipers("R6 protected write wiper", 8'h99, 8'h05, 8'h02, 8'h03);
        ev_stop();
        chk8("R9 no commit when blocked", {7'd0, commit}, 8'h00);
        nv_allow = 1'b1;
        ev_addr(8'h00);
        ev_rd(v);
        chk8("R9 dr kept", v, 8'h04);
        chk8("R11 row reload after read", wiper[7:0], 8'h04);
        ev_stop();
    endtask

    task automatic t_unused();
        logic [7:0] v;
        ev_addr(8'h05);
        ev_wr(8'h42);
        chk_wipers("R2 unused write ignored", 8'h04, 8'h05, 8'h02, 8'h03);
        ev_rd(v);
        chk8("R2 unused read", v, 8'h00);
        ev_stop();
        chk8("R2 nothing pended", {7'd0, commit}, 8'h00);
        ev_addr(8'h13);
        ev_rd(v);
        chk8("R2 high address unused", v, 8'h00);
        ev_stop();
    endtask

    task automatic t_row3();
        ev_addr(8'h07);
        ev_wr(8'h07);
        chk_wipers("R4 row3 load", 8'hDD, 8'hEE, 8'hFF, 8'h10);
        ev_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_read();
        t_wiper_write();
        t_status_load();
        t_abort();
        t_page();
        t_protect();
        t_unused();
        t_row3();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule